// File: doc/BRIEF.md
# Latched Network Error Status and Interrupt Unit

This unit gathers condition signals from the network and FIFO logic of a ring node into one 16-bit status word. Some of its bits are sticky. They latch a one-cycle condition and hold it until a clearing read by the host. The other bits show live levels. A 16-bit mask register chooses which sticky conditions may request the error interrupt. A master enable for interrupt-on-errors gates that request. The mask also drives a small general-purpose event counter. Counter overflow appears as one of the sticky conditions. Detecting the conditions is not part of this unit.

The error interrupt is a level driven by a three-state controller:
- `IRQ_ARMED`: no request is outstanding.
- `IRQ_FIRED`: the request is high and waits for the host to read the status word.
- `IRQ_DRAINED`: the request is still high, the status has been read, and the unit waits for a re-arm write.

The transitions are:
- **arm→fire**: the enable is set and an unmasked sticky bit is held.
- **fire→drain**: a clearing read occurs.
- **drain→arm**: a re-arm write occurs and nothing unmasked is pending.
- **drain→fire**: a re-arm write occurs and an unmasked bit is already pending again.

A write to the status address never changes the stored status. It only re-arms the interrupt.

The counter takes its event source from mask bits 14:13:
- 00: hold.
- 01: count trigger-1 pulses.
- 10: count trigger-2 pulses.
- 11: count error cycles.

A free-run input overrides the source and makes the counter advance on every clock.

Top module: `net_err_status`

## Requirements
- R1: After reset, the sticky status bits, the mask, the counter and the error interrupt are all zero.
- R2: Sticky bits 0, 4, 6, 7, 8, 9, 10, 11 and 13 set one cycle after their `cond_in` bit is high. They stay set until a cycle with `stat_rd` high, and the next cycle shows them cleared.
- R3: Status bits 1, 3, 5, 14 and 15 show `cond_in` in the same cycle, and `stat_rd` does not affect them.
- R4: Status bit 2 always reads 0, and `cond_in[2]` never raises the error interrupt.
- R5: A sticky condition that is high in the same cycle as a clearing read is set after that read.
- R6: `err_irq` rises one cycle after the stored state holds a sticky bit whose mask bit is 1 while `irq_err_en` is 1. A masked bit, or a clear enable, raises nothing.
- R7: Once high, `err_irq` stays high through the clearing read. A re-arm write (`stat_wr`) before that read does not drop it. A re-arm write never changes `stat_q`.
- R8: A re-arm write after the clearing read drops `err_irq` on the next cycle unless an unmasked sticky bit is pending then, in which case `err_irq` stays high.
- R9: A cycle with `mask_wr` high loads `wr_data` into `mask_q`, visible on the next cycle.
- R10: The counter source is mask[14:13]:
  - 00 holds.
  - 01 adds one per cycle with `trig1_in` high.
  - 10 adds one per cycle with `trig2_in` high.
  - 11 adds one per cycle in which any of `cond_in` bits 0, 4, 6-11 or 13 is high.

  With `free_run` high, the counter adds one every cycle whatever the source.
- R11: A count step from 16'hFFFF wraps to 0 and sets sticky bit 12. With mask bit 12 and the enable set, that raises `err_irq`.
- R12: `cond_in[12]` has no effect. Bit 12 is set only by counter overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_in | input | 16 | Condition pulses (sticky positions) and levels (live positions) |
| trig1_in | input | 1 | Trigger-1 event pulse |
| trig2_in | input | 1 | Trigger-2 event pulse |
| free_run | input | 1 | Counter counts every cycle |
| irq_err_en | input | 1 | Interrupt-on-errors enable |
| stat_rd | input | 1 | Clearing read of the status word |
| stat_wr | input | 1 | Write to status address (re-arm) |
| mask_wr | input | 1 | Load the mask register |
| wr_data | input | 16 | Mask write data |
| stat_q | output | 16 | Status word as the host reads it |
| mask_q | output | 16 | Mask register |
| count_q | output | 16 | Counter value |
| err_irq | output | 1 | Error interrupt request level |

## Verification
Counter overflow is the condition hardest to reach from the ports. It needs 65536 counting steps. The stimulus selects free-run and waits out the full wrap, with mask bit 12 and the enable set, so the sticky bit and the interrupt can be seen together.

The re-arm-with-pending path is also narrow. A fresh condition has to arrive between the clearing read and the re-arm write. The bench places a pulse in exactly that gap and also pulses a condition in the same cycle as a read.

A behavioural model tracks the sticky word, the mask, the counter and the interrupt phase, and is compared with every output on every clock.

// File: rtl/net_err_pkg.sv
package net_err_pkg;

    localparam int STAT_W = 16;

    // Positions that hold until a clearing read (bit 2 included but never set)
    localparam logic [STAT_W-1:0] STICKY_POS = 16'h3FD5;
    // Positions that follow the input level directly
    localparam logic [STAT_W-1:0] LIVE_POS   = ~STICKY_POS;

    localparam int ZERO_POS = 2;
    localparam int OVF_POS  = 12;

    // Sticky positions an external condition may set
    localparam logic [STAT_W-1:0] EXT_SET_POS =
        STICKY_POS & ~((STAT_W'(1) << ZERO_POS) | (STAT_W'(1) << OVF_POS));

    localparam int SRC_LO = 13;

    typedef enum logic [1:0] {
        IRQ_ARMED   = 2'd0,
        IRQ_FIRED   = 2'd1,
        IRQ_DRAINED = 2'd2
    } irq_st_e;

    typedef enum logic [1:0] {
        CNT_HOLD  = 2'd0,
        CNT_TRIG1 = 2'd1,
        CNT_TRIG2 = 2'd2,
        CNT_ERRS  = 2'd3
    } cnt_src_e;

endpackage

// File: rtl/net_err_latch.sv
module net_err_latch
    import net_err_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] cond_in,
    input  logic              ovf_pulse,
    input  logic              rd_clr,
    output logic [STAT_W-1:0] sticky_q,
    output logic [STAT_W-1:0] view_q,
    output logic              err_evt
);

    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] keep_vec;
    logic [STAT_W-1:0] sticky_d;

    always_comb begin
        set_vec = cond_in & EXT_SET_POS;
        set_vec[OVF_POS] = ovf_pulse;
        keep_vec = rd_clr ? (sticky_q & ~STICKY_POS) : sticky_q;
        sticky_d = (keep_vec | set_vec) & STICKY_POS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= sticky_d;
    end

    assign view_q  = (sticky_q & STICKY_POS) | (cond_in & LIVE_POS);
    assign err_evt = |(cond_in & EXT_SET_POS);

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

    // R5
    clear_keep_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> ((sticky_q & ~$past(set_vec)) == '0));

    // R4
    zero_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        view_q[ZERO_POS] == 1'b0);

endmodule

// File: rtl/net_err_cnt.sv
module net_err_cnt
    import net_err_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             free_run,
    input  cnt_src_e         src,
    input  logic             trig1,
    input  logic             trig2,
    input  logic             err_evt,
    output logic [CNT_W-1:0] count_q,
    output logic             ovf
);

    logic step;

    always_comb begin
        step = 1'b0;
        unique case (src)
            CNT_HOLD:  step = 1'b0;
            CNT_TRIG1: step = trig1;
            CNT_TRIG2: step = trig2;
            CNT_ERRS:  step = err_evt;
        endcase
        if (free_run) step = 1'b1;
    end

    assign ovf = step && (&count_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count_q <= '0;
        else if (step) count_q <= count_q + CNT_W'(1);
    end

    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count_q));

    // R11
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (count_q == '0));

endmodule

// File: rtl/net_err_irq_fsm.sv
module net_err_irq_fsm
    import net_err_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_en,
    input  logic pending,
    input  logic rd_clr,
    input  logic rearm,
    output logic irq
);

    irq_st_e state_q;
    irq_st_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_ARMED: begin
                if (irq_en && pending) state_d = IRQ_FIRED;
            end
            IRQ_FIRED: begin
                if (rd_clr) state_d = IRQ_DRAINED;
            end
            IRQ_DRAINED: begin
                if (rearm) state_d = (irq_en && pending) ? IRQ_FIRED : IRQ_ARMED;
            end
            default: state_d = IRQ_ARMED;
        endcase
    end

    always_comb begin
        unique case (state_q)
            IRQ_ARMED: irq = 1'b0;
            default:   irq = 1'b1;
        endcase
    end

    // R8
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(rearm));

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_en && pending));

    // R7
    irq_no_early_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_clr && state_q == IRQ_FIRED) |=> irq);

endmodule

// File: rtl/net_err_status.sv
module net_err_status
    import net_err_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] cond_in,
    input  logic              trig1_in,
    input  logic              trig2_in,
    input  logic              free_run,
    input  logic              irq_err_en,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] stat_q,
    output logic [STAT_W-1:0] mask_q,
    output logic [CNT_W-1:0]  count_q,
    output logic              err_irq
);

    logic [STAT_W-1:0] sticky_w;
    logic              ovf_w;
    logic              evt_w;
    logic              pending_w;
    cnt_src_e          src_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wr_data;
    end

    assign src_w     = cnt_src_e'(mask_q[SRC_LO+1:SRC_LO]);
    assign pending_w = |(sticky_w & mask_q & STICKY_POS);

    net_err_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_in   (cond_in),
        .ovf_pulse (ovf_w),
        .rd_clr    (stat_rd),
        .sticky_q  (sticky_w),
        .view_q    (stat_q),
        .err_evt   (evt_w)
    );

    net_err_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .free_run (free_run),
        .src      (src_w),
        .trig1    (trig1_in),
        .trig2    (trig2_in),
        .err_evt  (evt_w),
        .count_q  (count_q),
        .ovf      (ovf_w)
    );

    net_err_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_en  (irq_err_en),
        .pending (pending_w),
        .rd_clr  (stat_rd),
        .rearm   (stat_wr),
        .irq     (err_irq)
    );

    // R9
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_q == $past(wr_data)));

    // R12
    ovf_only_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ovf_w) && !$past(sticky_w[OVF_POS])) |-> !sticky_w[OVF_POS]);

endmodule

// File: tb/sim_net_err_status.sv
`timescale 1ns/1ps
module sim_net_err_status;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cond_in = '0;
    logic        trig1_in = 1'b0, trig2_in = 1'b0, free_run = 1'b0;
    logic        irq_err_en = 1'b0, stat_rd = 1'b0, stat_wr = 1'b0, mask_wr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] stat_q, mask_q, count_q;
    logic        err_irq;

    always #2.5 clk = ~clk;

    net_err_status u0 (
        .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .trig1_in(trig1_in),
        .trig2_in(trig2_in), .free_run(free_run), .irq_err_en(irq_err_en),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .mask_wr(mask_wr), .wr_data(wr_data),
        .stat_q(stat_q), .mask_q(mask_q), .count_q(count_q), .err_irq(err_irq)
    );

    // Behavioural reference model
    localparam logic [15:0] STICKY = 16'h3FD5;
    localparam logic [15:0] EXTSET = 16'h2FD1;
    logic [15:0] m_lat = '0, m_mask = '0, m_cnt = '0;
    int          m_phase = 0;   // 0 idle, 1 request up awaiting read, 2 read done awaiting re-arm
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;
    string       req = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lat = '0; m_mask = '0; m_cnt = '0; m_phase = 0;
        end else begin
            logic step, ovf, pend;
            logic [15:0] setv;
            case (m_mask[14:13])
                2'b00: step = 1'b0;
                2'b01: step = trig1_in;
                2'b10: step = trig2_in;
                default: step = |(cond_in & EXTSET);
            endcase
            if (free_run) step = 1'b1;
            ovf  = step && (m_cnt == 16'hFFFF);
            pend = |(m_lat & m_mask & STICKY);
            if (m_phase == 0) begin
                if (irq_err_en && pend) m_phase = 1;
            end else if (m_phase == 1) begin
                if (stat_rd) m_phase = 2;
            end else if (stat_wr) begin
                m_phase = (irq_err_en && pend) ? 1 : 0;
            end
            setv = (cond_in & EXTSET) | (ovf ? 16'h1000 : 16'h0000);
            m_lat = (stat_rd ? 16'h0000 : m_lat) | setv;
            if (mask_wr) m_mask = wr_data;
            if (step) m_cnt = m_cnt + 16'd1;
        end
    end

    always @(negedge clk) begin
        logic [15:0] exp_stat;
        exp_stat = (m_lat & STICKY) | (cond_in & ~STICKY);
        n_chk += 4;
        if (stat_q !== exp_stat) begin
            n_fail++; $display("FAIL %s stat_q actual %h expected %h at %0t", req, stat_q, exp_stat, $time);
        end
        if (mask_q !== m_mask) begin
            n_fail++; $display("FAIL %s mask_q actual %h expected %h at %0t", req, mask_q, m_mask, $time);
        end
        if (count_q !== m_cnt) begin
            n_fail++; $display("FAIL %s count_q actual %h expected %h at %0t", req, count_q, m_cnt, $time);
        end
        if (err_irq !== (m_phase != 0)) begin
            n_fail++; $display("FAIL %s err_irq actual %b expected %b at %0t", req, err_irq, (m_phase != 0), $time);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic clr_strobes();
        cond_in = '0; stat_rd = 0; stat_wr = 0; mask_wr = 0; trig1_in = 0; trig2_in = 0;
    endtask

    task automatic pulse_cond(input logic [15:0] v);
        cond_in = v; cyc(1); cond_in = '0;
    endtask

    task automatic do_read();
        stat_rd = 1; cyc(1); stat_rd = 0;
    endtask

    task automatic do_rearm();
        stat_wr = 1; cyc(1); stat_wr = 0;
    endtask

    task automatic load_mask(input logic [15:0] v);
        wr_data = v; mask_wr = 1; cyc(1); mask_wr = 0;
    endtask

    initial begin
        req = "R1"; cyc(3);
        rst_n = 1; cyc(2);

        req = "R9"; load_mask(16'h0F0F); cyc(1); load_mask(16'h0000); cyc(1);

        req = "R2"; pulse_cond(16'h0001); cyc(2); pulse_cond(16'h2FD0); cyc(3);
        do_read(); cyc(2);

        req = "R3"; cond_in = 16'hC02A; cyc(2); stat_rd = 1; cyc(1); stat_rd = 0;
        cond_in = 16'h4008; cyc(2); cond_in = '0; cyc(1);

        req = "R4"; irq_err_en = 1; load_mask(16'hFFFF); pulse_cond(16'h0004); cyc(3);

        req = "R12"; pulse_cond(16'h1000); cyc(3);

        req = "R5"; irq_err_en = 0; load_mask(16'h0000);
        pulse_cond(16'h0010); cond_in = 16'h0100; stat_rd = 1; cyc(1); clr_strobes(); cyc(2);
        do_read(); cyc(1);

        req = "R6"; irq_err_en = 1; load_mask(16'h0040);
        pulse_cond(16'h0080); cyc(3);
        irq_err_en = 0; pulse_cond(16'h0040); cyc(3);
        do_read(); cyc(1);
        irq_err_en = 1; pulse_cond(16'h0040); cyc(3);

        req = "R7"; do_rearm(); cyc(2); do_read(); cyc(3);

        req = "R8"; do_rearm(); cyc(2);
        pulse_cond(16'h0040); cyc(2); do_read(); cyc(1);
        pulse_cond(16'h0040); cyc(1); do_rearm(); cyc(2);
        do_read(); cyc(1); do_rearm(); cyc(2);

        req = "R10"; irq_err_en = 0; load_mask(16'h2000);
        trig1_in = 1; cyc(3); trig1_in = 0; trig2_in = 1; cyc(2); trig2_in = 0;
        load_mask(16'h4000); trig2_in = 1; cyc(4); trig2_in = 0; trig1_in = 1; cyc(2); trig1_in = 0;
        load_mask(16'h6000); pulse_cond(16'h0201); cond_in = 16'hC02A; cyc(2); cond_in = '0;
        pulse_cond(16'h2000); cyc(1);
        load_mask(16'h0000); trig1_in = 1; trig2_in = 1; cyc(2); clr_strobes();
        free_run = 1; cyc(5); free_run = 0; cyc(1);
        do_read(); do_rearm(); cyc(2);

        req = "R11"; irq_err_en = 1; load_mask(16'h1000); free_run = 1;
        cyc(65560); free_run = 0; cyc(3);
        do_read(); cyc(2); do_rearm(); cyc(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired during %s", req);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule